// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is an operating-system timer that sits behind a simple synchronous register port. A single 32-bit up-counter advances on every clock where the tick-enable input is high. Four channels each hold a 32-bit compare value. A channel latches a sticky status flag when the counter steps onto that compare value. Per-channel enable bits turn the status flags into interrupt lines. A sticky arming bit lets the last channel produce a one-cycle reset pulse, so that channel can serve as a watchdog.

Software loads the counter to restore a saved count. It programs a compare value some number of ticks ahead and enables the channel. When the interrupt arrives, it clears the status with a write-one-to-clear access. Every compare and enable register reads back, so the complete state can be saved and restored.

Top module: `ostmr_core`

## Requirements
- R1: Registers sit at byte offsets: compare n at 4*n (0x00, 0x04, 0x08, 0x0C), counter at 0x10, status at 0x14, watchdog arming at 0x18, interrupt enable at 0x1C. A read presented in a cycle returns its data on `bus_rdata` after that clock edge, and the data shows the register values from before the edge.
- R2: The counter increases by one on every clock edge where `tick_en` is high, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter loads the written value. When the write and a tick fall in the same cycle, the write takes priority.
- R4: A channel's status bit is set at the edge where a tick moves the counter onto that channel's compare value. Loading the counter with the compare value does not set it. A compare value the counter has already passed does not match again until the counter wraps.
- R5: Status bits 3..0 report channels 3..0, and the upper status bits read as zero.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged, so writing 0xF clears all four. When a new match lands in the same cycle as a clear, the match wins.
- R7: The compare registers and the interrupt enable register read back the values last written.
- R8: `irq_o[n]` equals status bit n AND enable bit n in every cycle. Clearing an enable bit drops its interrupt and leaves the compare value and the status bit as they were.
- R9: Watchdog arming bit 0 can be set by writing 1 and cannot be cleared by any write. While it is set, a channel 3 match drives `wdog_rst_o` high for exactly one cycle. While it is clear, the output stays low.
- R10: After reset the counter, all compare values, status, enables and the arming bit are zero, and `irq_o`, `wdog_rst_o` and `bus_rdata` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt lines |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest case to reach from the ports is a clear colliding with a fresh match. The bench sets the compare value one tick ahead and then issues the status write and the tick in the same cycle, so the set-wins rule shows up in the status value read afterwards. Wrap matching is reached by loading the counter just below 0xFFFFFFFF rather than waiting 2^32 ticks. A counter load onto a live compare value checks that only ticks trigger matches.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STAT,
    SEL_WDEN,
    SEL_IEN
  } reg_kind_e;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cnt_next_o,
  output logic          adv_o
);
  logic [DW-1:0] cnt_q;

  always_comb begin
    adv_o = tick_i & ~load_i;
    if (load_i)      cnt_next_o = load_val_i;
    else if (tick_i) cnt_next_o = cnt_q + DW'(1);
    else             cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i) |=> cnt_q == $past(cnt_q) + DW'(1));
  a_r3_count_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          match_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic [DW-1:0] cnt_next_i,
  input  logic          adv_i,
  output logic [DW-1:0] match_o,
  output logic          stat_o,
  output logic          stat_next_o,
  output logic          hit_o
);
  logic [DW-1:0] match_q;
  logic          stat_q;

  always_comb begin
    hit_o       = adv_i && (cnt_next_i == match_q);
    stat_next_o = hit_o | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      if (match_we_i) match_q <= wdata_i;
      stat_q <= stat_next_o;
    end
  end

  assign match_o = match_q;
  assign stat_o  = stat_q;

  a_r4_match_sets: assert property (@(posedge clk) disable iff (rst)
    (adv_i && cnt_next_i == match_q) |=> stat_q);
  a_r6_stat_hold: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !clr_i) |=> stat_q);
  a_r7_match_keep: assert property (@(posedge clk) disable iff (rst)
    !match_we_i |=> $stable(match_q));
endmodule

// File: rtl/ostmr_core.sv
module ostmr_core #(
  parameter int N_CH  = 4,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int WD_CH = N_CH - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [N_CH-1:0] irq_o,
  output logic            wdog_rst_o
);
  import ostmr_pkg::*;

  localparam int IDX_W    = AW - 2;
  localparam int CNT_IDX  = N_CH;
  localparam int STAT_IDX = N_CH + 1;
  localparam int WDEN_IDX = N_CH + 2;
  localparam int IEN_IDX  = N_CH + 3;

  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;

  always_comb begin
    idx  = bus_addr[AW-1:2];
    kind = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      if (int'(idx) < N_CH)           kind = SEL_MATCH;
      else if (int'(idx) == CNT_IDX)  kind = SEL_COUNT;
      else if (int'(idx) == STAT_IDX) kind = SEL_STAT;
      else if (int'(idx) == WDEN_IDX) kind = SEL_WDEN;
      else if (int'(idx) == IEN_IDX)  kind = SEL_IEN;
    end
    wr = bus_sel & bus_we;
    rd = bus_sel & ~bus_we;
  end

  logic [DW-1:0] cnt, cnt_next;
  logic          adv;

  ostmr_counter #(.DW(DW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_en),
    .load_i     (wr && kind == SEL_COUNT),
    .load_val_i (bus_wdata),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .adv_o      (adv)
  );

  logic [DW-1:0]   match_arr [N_CH];
  logic [N_CH-1:0] stat_vec, stat_next, hit_vec, clr_vec;

  assign clr_vec = (wr && kind == SEL_STAT) ? bus_wdata[N_CH-1:0] : '0;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    ostmr_chan #(.DW(DW)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .match_we_i  (wr && kind == SEL_MATCH && int'(idx) == n),
      .wdata_i     (bus_wdata),
      .clr_i       (clr_vec[n]),
      .cnt_next_i  (cnt_next),
      .adv_i       (adv),
      .match_o     (match_arr[n]),
      .stat_o      (stat_vec[n]),
      .stat_next_o (stat_next[n]),
      .hit_o       (hit_vec[n])
    );
  end

  logic [N_CH-1:0] ien_q, ien_next;
  logic            wden_q, wden_next;

  always_comb begin
    ien_next  = (wr && kind == SEL_IEN) ? bus_wdata[N_CH-1:0] : ien_q;
    wden_next = wden_q | (wr && kind == SEL_WDEN && bus_wdata[0]);
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (kind)
      SEL_MATCH: for (int n = 0; n < N_CH; n++)
                   if (int'(idx) == n) rd_mux = match_arr[n];
      SEL_COUNT: rd_mux = cnt;
      SEL_STAT:  rd_mux[N_CH-1:0] = stat_vec;
      SEL_WDEN:  rd_mux[0] = wden_q;
      SEL_IEN:   rd_mux[N_CH-1:0] = ien_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      wden_q     <= 1'b0;
      irq_o      <= '0;
      wdog_rst_o <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      ien_q      <= ien_next;
      wden_q     <= wden_next;
      irq_o      <= stat_next & ien_next;
      wdog_rst_o <= hit_vec[WD_CH] & wden_q;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_o == (stat_vec & ien_q));
  a_r9_wden_sticky: assert property (@(posedge clk) disable iff (rst)
    wden_q |=> wden_q);
  a_r9_wdog_single: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> !wdog_rst_o);
  a_r9_wdog_needs_stat: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |-> (stat_vec[WD_CH] && wden_q));
endmodule

// File: tb/sim_ostmr_core.sv
module sim_ostmr_core;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_M0 = 5'h00, A_M1 = 5'h04, A_M2 = 5'h08, A_M3 = 5'h0C;
  localparam logic [4:0] A_CNT = 5'h10, A_ST = 5'h14, A_WD = 5'h18, A_IE = 5'h1C;

  logic clk = 0, rst = 1, tick_en = 0, bus_sel = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  irq_o;
  logic        wdog_rst_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] exp_cnt = 0;
  logic [31:0] q_val[$];
  string       q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  ostmr_core u0 (.clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read result appears
  always begin
    bit fire;
    @(posedge clk);
    fire = bus_sel && !bus_we && !rst;
    @(negedge clk);
    if (fire) begin
      if (q_val.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
      end else chk(q_tag.pop_front(), bus_rdata, q_val.pop_front());
    end
  end

  task automatic bus_wr(logic [4:0] a, logic [31:0] d, bit with_tick = 0);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; tick_en = with_tick;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; tick_en = 0;
    if (a == A_CNT) exp_cnt = d;
    else if (with_tick) exp_cnt = exp_cnt + 1;
  endtask

  task automatic bus_rd(logic [4:0] a, logic [31:0] exp, string tag);
    q_val.push_back(exp); q_tag.push_back(tag);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic ticks(int k);
    tick_en = 1;
    repeat (k) @(negedge clk);
    tick_en = 0;
    exp_cnt = exp_cnt + k;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R10 reset state
    chk("R10 irq", {28'd0, irq_o}, 0);
    chk("R10 wdog", {31'd0, wdog_rst_o}, 0);
    chk("R10 rdata", bus_rdata, 0);
    for (int i = 0; i < 8; i++) bus_rd(5'(i*4), 0, "R10 reg after reset");
    // R7 / R1 readback at each offset
    bus_wr(A_M0, 32'h1111_0001); bus_wr(A_M1, 32'h2222_0002);
    bus_wr(A_M2, 32'h3333_0003); bus_wr(A_M3, 32'h4444_0004);
    bus_wr(A_IE, 32'hA);
    bus_rd(A_M0, 32'h1111_0001, "R7 match0"); bus_rd(A_M1, 32'h2222_0002, "R7 match1");
    bus_rd(A_M2, 32'h3333_0003, "R1 match2"); bus_rd(A_M3, 32'h4444_0004, "R1 match3");
    bus_rd(A_IE, 32'hA, "R7 ien");
    bus_wr(A_IE, 0);
    // R3 load, R2 step
    bus_wr(A_CNT, 100);
    bus_rd(A_CNT, 100, "R3 load");
    ticks(5);
    bus_rd(A_CNT, 105, "R2 count");
    bus_wr(A_CNT, 500, 1);
    bus_rd(A_CNT, 500, "R3 write beats tick");
    // R4/R5/R8 match on channel 1
    bus_wr(A_M1, exp_cnt + 6);
    bus_wr(A_IE, 32'h2);
    ticks(5);
    chk("R4 no early irq", {28'd0, irq_o}, 0);
    bus_rd(A_ST, 0, "R4 no early status");
    ticks(1);
    chk("R8 irq1", {28'd0, irq_o}, 32'h2);
    bus_rd(A_ST, 32'h2, "R5 status ch1");
    // R6 write-one-to-clear
    bus_wr(A_ST, 0);
    bus_rd(A_ST, 32'h2, "R6 zero write keeps");
    bus_wr(A_ST, 32'h2);
    chk("R6 irq after clear", {28'd0, irq_o}, 0);
    bus_rd(A_ST, 0, "R6 cleared");
    // R4 passed value does not re-fire; load onto compare does not fire
    ticks(20);
    bus_rd(A_ST, 0, "R4 passed value");
    bus_wr(A_CNT, 506);
    bus_rd(A_ST, 0, "R4 load onto match");
    // R2 wrap + R4 match at zero
    bus_wr(A_CNT, 32'hFFFF_FFFE);
    bus_wr(A_M2, 0);
    bus_wr(A_IE, 32'h4);
    ticks(1);
    chk("R4 before wrap", {28'd0, irq_o}, 0);
    ticks(1);
    chk("R4 irq at wrap", {28'd0, irq_o}, 32'h4);
    bus_rd(A_CNT, 0, "R2 wrap");
    // R8 gating
    bus_wr(A_M0, 3);
    ticks(3);
    bus_rd(A_ST, 32'h5, "R5 two channels");
    chk("R8 disabled ch0", {28'd0, irq_o}, 32'h4);
    bus_wr(A_IE, 32'h5);
    chk("R8 enable ch0", {28'd0, irq_o}, 32'h5);
    bus_wr(A_IE, 32'h4);
    chk("R8 disable ch0", {28'd0, irq_o}, 32'h4);
    bus_rd(A_M0, 3, "R8 match kept");
    bus_rd(A_ST, 32'h5, "R8 status kept");
    bus_wr(A_ST, 32'hF);
    bus_rd(A_ST, 0, "R6 clear all");
    // R6 set beats clear in the same cycle
    bus_wr(A_M0, exp_cnt + 1);
    bus_wr(A_ST, 32'h1, 1);
    bus_rd(A_ST, 32'h1, "R6 set wins");
    bus_wr(A_ST, 32'hF);
    // R9 watchdog
    bus_wr(A_M3, exp_cnt + 2);
    ticks(2);
    chk("R9 unarmed", {31'd0, wdog_rst_o}, 0);
    bus_rd(A_ST, 32'h8, "R5 status ch3");
    bus_wr(A_ST, 32'hF);
    bus_wr(A_WD, 0);
    bus_rd(A_WD, 0, "R9 zero write");
    bus_wr(A_WD, 1);
    bus_wr(A_WD, 0);
    bus_rd(A_WD, 1, "R9 sticky");
    bus_wr(A_M3, exp_cnt + 3);
    ticks(2);
    chk("R9 early", {31'd0, wdog_rst_o}, 0);
    ticks(1);
    chk("R9 pulse", {31'd0, wdog_rst_o}, 1);
    @(negedge clk);
    chk("R9 one cycle", {31'd0, wdog_rst_o}, 0);
    repeat (3) @(negedge clk);
    if (q_val.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 reads left actual=%0d expected=0", q_val.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule